// File: doc/BRIEF.md
# Frequency Counter Gate Sequencer

This block drives a gated frequency counter from a single fast reference clock. A programmable divider turns the reference into a slow base tick. A slot counter steps once per tick and splits each measurement cycle into a fixed number of slots. From the slot position the block decodes three strobes: a gate window, a one-cycle capture strobe that copies the finished count into a holding register, and a preset window that loads the counter's start value. Each cycle runs capture, then preset, then gate, and the gate and preset never overlap.

The measured signal is asynchronous. It passes through a synchroniser, and its rising edges are detected in the reference domain. Only edges that fall inside the gate window go on to a divide-by-ten prescaler. The prescaler emits a one-cycle counter clock on every tenth gated edge, and it is cleared during the preset window, so every gate starts from a zero residue. With the defaults (16 MHz reference, divisor 200000, 16 slots, 8 gate slots, 2 preset slots) the base tick is 80 Hz, the cycle is 200 ms, the gate is 100 ms and the preset window is 25 ms.

Top module: `fc_gate_sequencer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, gate_o, preset_o, capture_o and cnt_clk_o are low. The sequencer starts in slot GATE_SLOTS, the first closed slot.
- R2: After the k-th clock edge since reset release, the current slot is (GATE_SLOTS + floor(k/REF_DIV)) mod CYCLE_SLOTS. The slot therefore advances once every REF_DIV cycles, and a full cycle lasts CYCLE_SLOTS*REF_DIV cycles.
- R3: gate_o is high exactly while the slot is below GATE_SLOTS (slots 0 to 7 by default).
- R4: capture_o is high for exactly one cycle, in the first cycle of slot GATE_SLOTS, which is the cycle in which gate_o has just gone low. It never fires in the first cycle after reset.
- R5: preset_o is high exactly while the slot lies in PRESET_FIRST to PRESET_FIRST+PRESET_SLOTS-1 (slots 12 and 13 by default). This places it after capture and before the next gate.
- R6: meas_in passes through SYNC_STAGES flops. Only its rising edges count, and only those seen while gate_o is high. Edges seen while the gate is closed have no effect on cnt_clk_o.
- R7: cnt_clk_o pulses for one cycle on every PRESCALE-th gated rising edge. A gate that contains N edges gives floor(N/PRESCALE) pulses. A pulse appears SYNC_STAGES+1 cycles after the input rises.
- R8: The prescaler residue is cleared during preset_o. A gate with 7 edges followed by a gate with 3 edges gives no pulse in either gate.
- R9: gate_o and preset_o are never high together, and capture_o is never high together with either of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| meas_in | input | 1 | Asynchronous measured pulse stream |
| gate_o | output | 1 | Gate window, high while input edges are counted |
| preset_o | output | 1 | Counter preset window |
| capture_o | output | 1 | One-cycle strobe that captures the finished count |
| cnt_clk_o | output | 1 | Prescaled counter clock, one pulse per PRESCALE gated edges |

## Verification
The three strobes are combinational decodes of registered state. Each one is due in the same cycle as the clock edge that changes the slot, so the bench keeps its own count of edges since reset and predicts all three at every falling edge of the whole run. A counter clock pulse appears three cycles after the input rises: two synchroniser flops, then the prescaler register. The bench therefore drives pulses only from eight cycles after a gate opens to eight cycles before it closes, and it sums the pulses over a window that ends well before the preset. Pulses driven in the closed half of each cycle test the gating. A 7-then-3 pair of gates tests the clear.

// File: rtl/fcgs_pkg.sv
// Shared helpers for the frequency counter gate sequencer.
// Assumes: widths are derived from positive parameter values.
package fcgs_pkg;
    // Width needed to hold values 0 .. n-1 (at least one bit).
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/fcgs_tick_div.sv
// Reference divider: emits a one-cycle tick every DIV reference cycles.
// Assumes: DIV >= 2; counter restarts from zero on reset.
module fcgs_tick_div #(
    parameter int DIV = 200000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = fcgs_pkg::cnt_width(DIV);
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    // Free-running modulo-DIV counter.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + W'(1);
    end

    assign tick = (cnt == LAST);

    // R2
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/fcgs_phase_seq.sv
// Phase sequencer: steps a slot counter per base tick and decodes the
// gate window, the preset window and a one-cycle capture strobe.
// Assumes: PRESET window lies strictly between GATE_SLOTS and CYCLE_SLOTS.
module fcgs_phase_seq #(
    parameter int CYCLE_SLOTS  = 16,
    parameter int GATE_SLOTS   = 8,
    parameter int PRESET_FIRST = 12,
    parameter int PRESET_SLOTS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic gate,
    output logic preset,
    output logic capture
);
    localparam int SW = fcgs_pkg::cnt_width(CYCLE_SLOTS);
    localparam logic [SW-1:0] SLOT_LAST  = SW'(CYCLE_SLOTS - 1);
    localparam logic [SW-1:0] SLOT_CLOSE = SW'(GATE_SLOTS);
    localparam logic [SW-1:0] SLOT_OPENL = SW'(GATE_SLOTS - 1);
    localparam logic [SW-1:0] PRE_LO     = SW'(PRESET_FIRST);
    localparam logic [SW-1:0] PRE_HI     = SW'(PRESET_FIRST + PRESET_SLOTS - 1);

    logic [SW-1:0] slot;
    logic          cap_q;

    // Slot counter advances on each tick; reset parks it in the first closed slot.
    always_ff @(posedge clk) begin
        if (!rst_n)             slot <= SLOT_CLOSE;
        else if (tick)          slot <= (slot == SLOT_LAST) ? '0 : slot + SW'(1);
    end

    // Capture strobe fires in the first cycle after the gate closes.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= 1'b0;
        else        cap_q <= tick && (slot == SLOT_OPENL);
    end

    assign gate    = (slot < SLOT_CLOSE);
    assign preset  = (slot >= PRE_LO) && (slot <= PRE_HI);
    assign capture = cap_q;

    // R4
    cap_after_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate) |-> capture);
    // R4
    cap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !capture);
    // R5
    preset_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(preset) |-> $past(!gate && !capture));
endmodule

// File: rtl/fcgs_pulse_gate.sv
// Pulse path: synchronises the measured input, detects rising edges,
// passes only those inside the gate and divides them by PRESCALE.
// Assumes: input pulses are high and low for at least one reference cycle
// each; clr and gate are never high together.
module fcgs_pulse_gate #(
    parameter int SYNC_STAGES = 2,
    parameter int PRESCALE    = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic meas_in,
    input  logic gate,
    input  logic clr,
    output logic cnt_clk
);
    localparam int PW = fcgs_pkg::cnt_width(PRESCALE);
    localparam logic [PW-1:0] PC_LAST = PW'(PRESCALE - 1);

    logic [SYNC_STAGES-1:0] sy;
    logic                   prev;
    logic                   rise;
    logic [PW-1:0]          pc;
    logic                   out_q;

    // Synchroniser chain, one flop per stage.
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            // First stage samples the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) sy[0] <= 1'b0;
                else        sy[0] <= meas_in;
            end
        end else begin : g_next
            // Later stages resample the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) sy[g] <= 1'b0;
                else        sy[g] <= sy[g-1];
            end
        end
    end

    // Delayed copy for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= sy[SYNC_STAGES-1];
    end

    assign rise = sy[SYNC_STAGES-1] && !prev;

    // Divide-by-PRESCALE of gated edges, cleared in the preset window.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)      pc <= '0;
        else if (rise && gate)  pc <= (pc == PC_LAST) ? '0 : pc + PW'(1);
    end

    // One-cycle counter clock on the wrapping edge.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= rise && gate && !clr && (pc == PC_LAST);
    end

    assign cnt_clk = out_q;

    // R7
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    // R7
    pc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc <= PC_LAST);
    // R7
    cnt_clk_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clk |=> !cnt_clk);
    // R6
    cnt_clk_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clk |-> $past(gate));
    // R8
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pc == '0));
endmodule

// File: rtl/fc_gate_sequencer.sv
// Top: gate sequencer for a gated frequency counter. Divides the reference
// to a base tick, sequences capture, preset and gate within each cycle,
// and prescales the gated measured edges into a counter clock.
// Assumes: REF_DIV >= 2, PRESCALE >= 2, GATE_SLOTS < PRESET_FIRST and
// PRESET_FIRST + PRESET_SLOTS <= CYCLE_SLOTS.
module fc_gate_sequencer #(
    parameter int REF_DIV      = 200000,
    parameter int CYCLE_SLOTS  = 16,
    parameter int GATE_SLOTS   = 8,
    parameter int PRESET_FIRST = 12,
    parameter int PRESET_SLOTS = 2,
    parameter int SYNC_STAGES  = 2,
    parameter int PRESCALE     = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic meas_in,
    output logic gate_o,
    output logic preset_o,
    output logic capture_o,
    output logic cnt_clk_o
);
    logic tick;

    fcgs_tick_div #(.DIV(REF_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    fcgs_phase_seq #(
        .CYCLE_SLOTS  (CYCLE_SLOTS),
        .GATE_SLOTS   (GATE_SLOTS),
        .PRESET_FIRST (PRESET_FIRST),
        .PRESET_SLOTS (PRESET_SLOTS)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .gate    (gate_o),
        .preset  (preset_o),
        .capture (capture_o)
    );

    fcgs_pulse_gate #(
        .SYNC_STAGES (SYNC_STAGES),
        .PRESCALE    (PRESCALE)
    ) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .meas_in (meas_in),
        .gate    (gate_o),
        .clr     (preset_o),
        .cnt_clk (cnt_clk_o)
    );

    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_o && preset_o));
    // R9
    cap_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture_o |-> (!gate_o && !preset_o));
endmodule

// File: tb/tb_fc_gate_sequencer.sv
module tb_fc_gate_sequencer;
    localparam int D   = 20;
    localparam int CS  = 16;
    localparam int GS  = 8;
    localparam int PF  = 12;
    localparam int PS  = 2;
    localparam int PRE = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic meas_in = 1'b0;
    logic gate_o, preset_o, capture_o, cnt_clk_o;

    int checks = 0;
    int fails  = 0;
    int k      = 0;
    int pulses = 0;
    int caps   = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    fc_gate_sequencer #(
        .REF_DIV(D), .CYCLE_SLOTS(CS), .GATE_SLOTS(GS),
        .PRESET_FIRST(PF), .PRESET_SLOTS(PS),
        .SYNC_STAGES(2), .PRESCALE(PRE)
    ) dut (
        .clk(clk), .rst_n(rst_n), .meas_in(meas_in),
        .gate_o(gate_o), .preset_o(preset_o),
        .capture_o(capture_o), .cnt_clk_o(cnt_clk_o)
    );

    // Edges counted since reset release.
    always_ff @(posedge clk) if (rst_n) k <= k + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (k=%0d)", req, act, exp, k);
        end
    endtask

    // Per-cycle prediction of every strobe from the edge count.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            automatic int m    = k / D;
            automatic int slot = (GS + m) % CS;
            automatic bit eg   = (slot < GS);
            automatic bit ep   = (slot >= PF) && (slot < PF + PS);
            automatic bit ec   = (k % D == 0) && (m > 0) && (slot == GS);
            check(gate_o == eg,    "R2 R3 gate",    gate_o,    eg);
            check(preset_o == ep,  "R5 preset",     preset_o,  ep);
            check(capture_o == ec, "R4 capture",    capture_o, ec);
            check(!(gate_o && preset_o), "R9 overlap", gate_o && preset_o, 0);
            if (capture_o) caps++;
            if (cnt_clk_o) pulses++;
        end
    end

    task automatic wait_k(input int t);
        while (k < t) @(negedge clk);
    endtask

    task automatic drive_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            meas_in = 1'b1;
            repeat (2) @(negedge clk);
            meas_in = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    // One measurement cycle: n edges inside the gate, extra edges outside.
    task automatic run_gate(input int j, input int n, input int outside, input int exp, input string req);
        automatic int gs0 = (GS + CS * j) * D;
        automatic int p0;
        wait_k(gs0);
        p0 = pulses;
        wait_k(gs0 + 8);
        drive_pulses(n);
        wait_k(gs0 + GS * D + 20);
        drive_pulses(outside);
        wait_k(gs0 + PF * D - 4);
        check(pulses - p0 == exp, req, pulses - p0, exp);
    endtask

    function automatic string fmt_summary();
        return $sformatf("%0d/%0d checks passed", checks - fails, checks);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset
        check({gate_o, preset_o, capture_o, cnt_clk_o} == 4'b0, "R1 reset outputs",
              {gate_o, preset_o, capture_o, cnt_clk_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: still closed right after release
        check(!gate_o && !capture_o, "R1 post-release", gate_o, 0);

        run_gate(0, 0,  0, 0, "R7 zero edges");
        run_gate(1, 9,  0, 0, "R7 nine edges");
        run_gate(2, 10, 0, 1, "R7 ten edges");
        run_gate(3, 25, 8, 2, "R6 R7 25 edges with closed-gate edges");
        run_gate(4, 36, 0, 3, "R7 36 edges");
        run_gate(5, 7,  0, 0, "R8 seven edges");
        run_gate(6, 3,  0, 0, "R8 residue cleared");
        run_gate(7, 0,  9, 0, "R6 closed-gate edges only");
        run_gate(8, 20, 0, 2, "R7 twenty edges");

        // R2: one capture per full cycle
        wait_k((GS + CS * 9) * D + 2);
        check(caps == 9, "R2 capture count", caps, 9);

        done = 1'b1;
        $display("%s", fmt_summary());
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", k, 0);
            $display("%s", fmt_summary());
            $finish;
        end
    end
endmodule